// File: doc/BRIEF.md
# Dual-Output Programmable Interrupt Controller

This block gathers a set of interrupt lines (32 by default) and turns them into two processor requests: a normal request and a fast request. Each request has its own register bank. Software sets, per bank and per line, whether the line is enabled, whether it is detected by level or by edge, and which level or edge counts as active. It then reads back a raw pending view, reads a masked status, and acknowledges edge events by writing ones to a clear register. The two banks watch the same synchronised inputs but have no configuration or pending state in common.

Inputs are asynchronous. Each line passes through a two-flop synchroniser. A third flop holds the previous synchronised value, and edge detection compares against it. Edge events stay latched until software acknowledges them. Level lines simply follow their input. Each bank also presents the index of its lowest pending enabled line, so that software can dispatch without scanning. A single-cycle bus carries register access. A write takes effect at the clock edge on which it is presented. Read data is combinational from the address.

Top module: `dual_irq_ctrl`

## Requirements
- R1: After reset the mask, mode and polarity registers of both banks read zero, no edge event is pending, status reads zero and both request outputs are low.
- R2: Bus byte address bit 5 selects the bank (0 normal, 1 fast). Address bits 4:2 select the register: 0 source, 1 mask, 2 clear, 3 mode, 4 polarity, 5 status. Mask, mode and polarity read back what was written. Writes to source or status change nothing, and the clear register reads as zero.
- R3: Status equals source AND mask, with bit n for line n. A mask bit of 0 keeps its line out of status and out of the request, so an all-zero mask silences the bank.
- R4: With mode bit 0 the line is level sensitive. Polarity 0 makes a high input active and polarity 1 makes a low input active. The source bit follows the corrected input.
- R5: With mode bit 1 the line is edge triggered. Polarity 0 latches a pending bit on a rising edge and polarity 1 latches it on a falling edge. The bit stays set after the input returns.
- R6: A write to clear drops the edge-pending bits at the positions written as 1. Positions written as 0 stay as they were. On level-mode lines a clear has no lasting effect.
- R7: If an edge is detected in the same cycle that a clear for that line takes effect, the pending bit remains set.
- R8: Each request output is the OR of its bank's status, registered: it changes one clock edge after status changes.
- R9: Each bank's first-index output gives the lowest set bit position of its status, and 0 when status is zero.
- R10: The banks are independent: configuration or acknowledgement in one bank never alters the other bank's source, status or request.
- R11: An input change reaches a level-mode source bit after two clock edges and an edge-pending bit after three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lines_i | input | 32 | Asynchronous interrupt lines, bit n is line n |
| bus_addr_i | input | 6 | Register byte address |
| bus_wr_i | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| norm_req_o | output | 1 | Normal interrupt request |
| fast_req_o | output | 1 | Fast interrupt request |
| norm_first_o | output | 5 | Lowest pending enabled line of the normal bank |
| fast_first_o | output | 5 | Lowest pending enabled line of the fast bank |

## Verification
A line change driven between edges reaches a level-mode source and status bit after the second rising edge. It reaches an edge-pending bit after the third, and the request output one edge after status. Register writes are visible on read data right after the edge that samples them. The bench drives lines and bus on falling edges. It lets at least five edges pass before comparing source, status, first index and requests, except in the directed timing cases, which sample at the exact falling edges on either side of the expected change. Those cases include the request delay and the clear that coincides with a new edge.

// File: rtl/idc_pkg.sv
`timescale 1ns/1ps
package idc_pkg;
    localparam int IDC_BANKS    = 2;
    localparam int IDC_ADDR_W   = 6;
    localparam int IDC_BANK_BIT = 5;

    typedef enum logic [2:0] {
        SEL_SRC  = 3'd0,
        SEL_MASK = 3'd1,
        SEL_CLR  = 3'd2,
        SEL_MODE = 3'd3,
        SEL_POL  = 3'd4,
        SEL_STAT = 3'd5
    } reg_sel_e;
endpackage

// File: rtl/idc_sync.sv
`timescale 1ns/1ps
module idc_sync #(
    parameter int N = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o,
    output logic [N-1:0] prev_o
);
    typedef struct packed {
        logic [N-1:0] meta;
        logic [N-1:0] stable;
        logic [N-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.meta   = async_i;
        st_d.stable = st_q.meta;
        st_d.prev   = st_q.stable;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign sync_o = st_q.stable;
    assign prev_o = st_q.prev;
endmodule

// File: rtl/idc_bank.sv
`timescale 1ns/1ps
module idc_bank
    import idc_pkg::*;
#(
    parameter int N = 32,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [N-1:0]  sync_i,
    input  logic [N-1:0]  prev_i,
    input  logic          wr_i,
    input  logic [2:0]    wr_sel_i,
    input  logic [N-1:0]  wdata_i,
    input  logic [2:0]    rd_sel_i,
    output logic [N-1:0]  rdata_o,
    output logic [N-1:0]  status_o,
    output logic [N-1:0]  mask_o,
    output logic          req_o,
    output logic [IW-1:0] first_o
);
    typedef struct packed {
        logic [N-1:0] mask;
        logic [N-1:0] mode;
        logic [N-1:0] pol;
        logic [N-1:0] pend;
        logic         req;
    } bank_t;

    bank_t st_d, st_q;

    logic [N-1:0] level_act;
    logic [N-1:0] edge_hit;
    logic [N-1:0] clr_bits;
    logic [N-1:0] src;
    logic [N-1:0] stat;
    logic [IW-1:0] first;

    always_comb begin
        level_act = sync_i ^ st_q.pol;
        edge_hit  = (~st_q.pol & sync_i & ~prev_i) | (st_q.pol & ~sync_i & prev_i);
        clr_bits  = (wr_i && reg_sel_e'(wr_sel_i) == SEL_CLR) ? wdata_i : '0;
        src       = (st_q.mode & st_q.pend) | (~st_q.mode & level_act);
        stat      = src & st_q.mask;

        st_d      = st_q;
        if (wr_i) begin
            case (reg_sel_e'(wr_sel_i))
                SEL_MASK: st_d.mask = wdata_i;
                SEL_MODE: st_d.mode = wdata_i;
                SEL_POL:  st_d.pol  = wdata_i;
                default:  ;
            endcase
        end
        st_d.pend = st_q.mode & ((st_q.pend & ~clr_bits) | edge_hit);
        st_d.req  = |stat;
    end

    always_comb begin
        first = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (stat[i]) first = IW'(i);
        end
    end

    always_comb begin
        case (reg_sel_e'(rd_sel_i))
            SEL_SRC:  rdata_o = src;
            SEL_MASK: rdata_o = st_q.mask;
            SEL_MODE: rdata_o = st_q.mode;
            SEL_POL:  rdata_o = st_q.pol;
            SEL_STAT: rdata_o = stat;
            default:  rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign status_o = stat;
    assign mask_o   = st_q.mask;
    assign req_o    = st_q.req;
    assign first_o  = first;
endmodule

// File: rtl/dual_irq_ctrl.sv
`timescale 1ns/1ps
module dual_irq_ctrl
    import idc_pkg::*;
#(
    parameter int NLINES = 32,
    localparam int IW = (NLINES > 1) ? $clog2(NLINES) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NLINES-1:0] lines_i,
    input  logic [IDC_ADDR_W-1:0] bus_addr_i,
    input  logic              bus_wr_i,
    input  logic [NLINES-1:0] bus_wdata_i,
    output logic [NLINES-1:0] bus_rdata_o,
    output logic              norm_req_o,
    output logic              fast_req_o,
    output logic [IW-1:0]     norm_first_o,
    output logic [IW-1:0]     fast_first_o
);
    logic [NLINES-1:0] sync_w;
    logic [NLINES-1:0] prev_w;
    logic [NLINES-1:0] rd_w   [IDC_BANKS];
    logic [NLINES-1:0] stat_w [IDC_BANKS];
    logic [NLINES-1:0] mask_w [IDC_BANKS];
    logic              req_w  [IDC_BANKS];
    logic [IW-1:0]     first_w[IDC_BANKS];
    logic              aligned;
    logic [2:0]        sel;

    assign aligned = (bus_addr_i[1:0] == 2'b00);
    assign sel     = bus_addr_i[4:2];

    idc_sync #(.N(NLINES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (lines_i),
        .sync_o  (sync_w),
        .prev_o  (prev_w)
    );

    for (genvar b = 0; b < IDC_BANKS; b++) begin : g_bank
        logic hit;
        assign hit = aligned && (bus_addr_i[IDC_BANK_BIT] == b[0]);

        idc_bank #(.N(NLINES)) u_bank (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .sync_i   (sync_w),
            .prev_i   (prev_w),
            .wr_i     (bus_wr_i && hit),
            .wr_sel_i (sel),
            .wdata_i  (bus_wdata_i),
            .rd_sel_i (sel),
            .rdata_o  (rd_w[b]),
            .status_o (stat_w[b]),
            .mask_o   (mask_w[b]),
            .req_o    (req_w[b]),
            .first_o  (first_w[b])
        );
    end

    assign bus_rdata_o  = aligned ? rd_w[bus_addr_i[IDC_BANK_BIT]] : '0;
    assign norm_req_o   = req_w[0];
    assign fast_req_o   = req_w[1];
    assign norm_first_o = first_w[0];
    assign fast_first_o = first_w[1];
endmodule

// File: rtl/idc_checker.sv
`timescale 1ns/1ps
module idc_checker #(
    parameter int N  = 32,
    parameter int IW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic [5:0]    bus_addr,
    input logic          bus_wr,
    input logic [N-1:0]  bus_wdata,
    input logic [N-1:0]  norm_stat,
    input logic [N-1:0]  fast_stat,
    input logic [N-1:0]  norm_mask,
    input logic          norm_req,
    input logic          fast_req,
    input logic [IW-1:0] norm_first,
    input logic [IW-1:0] fast_first
);
    a_r8_norm_req: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (norm_req == (|$past(norm_stat))));

    a_r8_fast_req: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (fast_req == (|$past(fast_stat))));

    a_r9_norm_first: assert property (@(posedge clk) disable iff (!rst_n)
        (norm_stat != '0) |-> (norm_stat[norm_first] &&
            ((norm_stat & ((N'(1) << norm_first) - N'(1))) == '0)));

    a_r9_fast_first: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_stat == '0) |-> (fast_first == '0));

    a_r3_mask_zero_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (norm_mask == '0) |-> (norm_stat == '0));

    a_r2_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 6'h04) |=> (norm_mask == $past(bus_wdata)));
endmodule

bind dual_irq_ctrl idc_checker #(.N(NLINES), .IW(IW)) u_chk (
    .clk        (clk_i),
    .rst_n      (rst_ni),
    .bus_addr   (bus_addr_i),
    .bus_wr     (bus_wr_i),
    .bus_wdata  (bus_wdata_i),
    .norm_stat  (stat_w[0]),
    .fast_stat  (stat_w[1]),
    .norm_mask  (mask_w[0]),
    .norm_req   (norm_req_o),
    .fast_req   (fast_req_o),
    .norm_first (norm_first_o),
    .fast_first (fast_first_o)
);

// File: tb/tb_dual_irq_ctrl.sv
`timescale 1ns/1ps
module tb_dual_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lines = '0;
    logic [5:0]  addr = '0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        nreq, freq;
    logic [4:0]  nfirst, ffirst;
    int          checks = 0;
    int          errors = 0;

    localparam logic [5:0] O_SRC = 6'h00, O_MASK = 6'h04, O_CLR = 6'h08,
                           O_MODE = 6'h0C, O_POL = 6'h10, O_STAT = 6'h14;
    localparam logic [5:0] FAST = 6'h20;

    always #10 clk = ~clk;

    dual_irq_ctrl dut (
        .clk_i(clk), .rst_ni(rst_n), .lines_i(lines),
        .bus_addr_i(addr), .bus_wr_i(wr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .norm_req_o(nreq), .fast_req_o(freq),
        .norm_first_o(nfirst), .fast_first_o(ffirst)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; #1 d = rdata;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] exp_src(input logic [31:0] mode, input logic [31:0] pol,
                                            input logic [31:0] a, input logic [31:0] b);
        logic [31:0] lvl, edg;
        lvl = b ^ pol;
        edg = (~pol & ~a & b) | (pol & a & ~b);
        return (mode & edg) | (~mode & lvl);
    endfunction

    function automatic logic [4:0] exp_first(input logic [31:0] s);
        for (int i = 31; i >= 0; i--) if (s[i]) exp_first = 5'(i);
        if (s == '0) exp_first = '0;
    endfunction

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] mk[2], md[2], pl[2];
        logic [31:0] a, b, es;
        void'($urandom(32'd1234));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int k = 0; k < 2; k++) begin
            logic [5:0] base;
            base = k ? FAST : 6'h00;
            rd_reg(base | O_MASK, v); check("R1 mask", v, 0);
            rd_reg(base | O_MODE, v); check("R1 mode", v, 0);
            rd_reg(base | O_POL,  v); check("R1 pol",  v, 0);
            rd_reg(base | O_STAT, v); check("R1 status", v, 0);
        end
        check("R1 requests", {nreq, freq}, 0);

        // R2 readback, read-only registers, clear reads zero
        wr_reg(O_POL, 32'h0000_00F0);
        rd_reg(O_POL, v); check("R2 pol readback", v, 32'h0000_00F0);
        settle(4);
        rd_reg(O_SRC, v); check("R2 src before", v, 32'h0000_00F0);
        wr_reg(O_SRC, 32'h0); wr_reg(O_STAT, 32'hFFFF_FFFF);
        rd_reg(O_SRC, v); check("R2 src write ignored", v, 32'h0000_00F0);
        rd_reg(O_STAT, v); check("R2 status write ignored", v, 32'h0);
        rd_reg(O_CLR, v); check("R2 clear reads zero", v, 32'h0);
        rd_reg(FAST | O_SRC, v); check("R10 fast untouched", v, 32'h0);
        wr_reg(O_POL, 32'h0);

        // R8 and R11 level timing: line 3 active high, normal bank
        wr_reg(O_MASK, 32'h8);
        settle(3);
        @(negedge clk); lines[3] = 1'b1; addr = O_STAT;
        @(negedge clk); #1 check("R11 status after one edge", rdata, 0);
        @(negedge clk); #1 check("R11 status after two edges", rdata, 32'h8);
        check("R8 request not yet", nreq, 1'b0);
        @(negedge clk); check("R8 request one edge later", nreq, 1'b1);
        check("R9 first index", nfirst, 5'd3);
        check("R10 fast request idle", freq, 1'b0);
        wr_reg(O_CLR, 32'h8); settle(1);
        rd_reg(O_STAT, v); check("R6 clear ignored on level", v, 32'h8);
        lines[3] = 1'b0; settle(4);
        rd_reg(O_STAT, v); check("R4 level released", v, 0);

        // R4 active low in fast bank
        wr_reg(FAST | O_POL, 32'h20); wr_reg(FAST | O_MASK, 32'h20); settle(4);
        check("R4 active low request", freq, 1'b1);
        check("R10 normal unaffected", nreq, 1'b0);
        wr_reg(FAST | O_MASK, 32'h0); settle(2);
        check("R3 mask zero silences", freq, 1'b0);
        wr_reg(FAST | O_POL, 32'h0);

        // R5 and R6: rising on line 1, falling on line 2
        wr_reg(O_MODE, 32'h6); wr_reg(O_POL, 32'h4); wr_reg(O_MASK, 32'h6);
        lines[2] = 1'b1; settle(5); wr_reg(O_CLR, 32'hFFFF_FFFF); settle(1);
        rd_reg(O_SRC, v); check("R5 idle edges", v, 0);
        @(negedge clk); lines[1] = 1'b1; lines[2] = 1'b0;
        settle(2); @(negedge clk); lines[1] = 1'b0; lines[2] = 1'b1; settle(5);
        rd_reg(O_SRC, v); check("R5 edges latched", v, 32'h6);
        wr_reg(O_CLR, 32'h2);
        rd_reg(O_SRC, v); check("R6 selective clear", v, 32'h4);
        wr_reg(O_CLR, 32'h4);
        rd_reg(O_SRC, v); check("R6 clear second", v, 0);

        // R7 edge coincides with clear, and R11 edge latency
        @(negedge clk); lines[1] = 1'b1; addr = O_SRC;
        @(negedge clk); #1 check("R11 edge after one", rdata, 0);
        @(negedge clk); #1 check("R11 edge after two", rdata, 0);
        addr = O_CLR; wdata = 32'h2; wr = 1'b1;
        @(negedge clk); wr = 1'b0; addr = O_SRC; #1 check("R7 edge survives clear", rdata, 32'h2);
        wr_reg(O_CLR, 32'h2);
        rd_reg(O_SRC, v); check("R7 later clear works", v, 0);
        lines = '0; settle(5);
        wr_reg(O_CLR, 32'hFFFF_FFFF);

        // Random: both banks, random config and line transitions
        for (int it = 0; it < 60; it++) begin
            for (int k = 0; k < 2; k++) begin
                mk[k] = $urandom; md[k] = $urandom; pl[k] = $urandom;
                wr_reg((k ? FAST : 6'h00) | O_MASK, mk[k]);
                wr_reg((k ? FAST : 6'h00) | O_MODE, md[k]);
                wr_reg((k ? FAST : 6'h00) | O_POL,  pl[k]);
            end
            a = $urandom; b = $urandom;
            if (it % 7 == 0) b = a;
            @(negedge clk); lines = a; settle(5);
            wr_reg(O_CLR, 32'hFFFF_FFFF); wr_reg(FAST | O_CLR, 32'hFFFF_FFFF); settle(1);
            @(negedge clk); lines = b; settle(5);
            for (int k = 0; k < 2; k++) begin
                logic [5:0] base;
                base = k ? FAST : 6'h00;
                es = exp_src(md[k], pl[k], a, b);
                rd_reg(base | O_SRC, v);  check("R4 R5 random source", v, es);
                rd_reg(base | O_STAT, v); check("R3 random status", v, es & mk[k]);
                rd_reg(base | O_MASK, v); check("R2 random mask", v, mk[k]);
                if (k == 0) begin
                    check("R8 random normal request", nreq, |(es & mk[k]));
                    check("R9 random normal first", nfirst, exp_first(es & mk[k]));
                end else begin
                    check("R10 random fast request", freq, |(es & mk[k]));
                    check("R9 random fast first", ffirst, exp_first(es & mk[k]));
                end
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule